// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block is the address engine of a bus-mastering DMA channel. Software builds a table of 8-byte descriptors in memory; each one names a memory region and how many bytes it holds. After a start pulse the walker reads descriptors one at a time through a small fetch port. It then breaks the current region into burst requests for the memory interconnect. The device side says how many bytes it has to move and in which direction; the data beats themselves travel on the interconnect and are not handled here.

A burst never crosses a region boundary and never asks for more bytes than the device has left. Its length is also capped at a fixed number of bus words. The walk ends in one of two ways. A `done` pulse means every device byte was covered. A `tbl_end` pulse means the table ran out while device bytes remained, either at a descriptor flagged as last or after one page of table has been read. A synchronous clear input drops whatever is left of the region currently being worked on.

Top module: `sg_walker`

## Requirements
- R1: A descriptor arrives on `dsc_rdata` with the region address in bits [31:0] and the control word in bits [63:32]. The region length is control bits [15:0] with bit 0 forced to zero. Control bits [30:16] and bit 0 have no effect on any request.
- R2: A decoded region length of zero stands for 65536 bytes.
- R3: Control bit 31 marks the last descriptor. Once that region is used up, no further descriptor is fetched. If device bytes remain, `tbl_end` pulses for one cycle.
- R4: The first descriptor is read from `tbl_base` and each later one from the previous address plus 8. A fetch is requested only when the current region has no bytes left. `dsc_req` and `dsc_addr` hold steady until `dsc_ack`.
- R5: When the region is empty and the table pointer sits 4096 or more bytes past `tbl_base`, the walk stops with `tbl_end` and issues no fetch. With a table of unflagged entries this happens after exactly 512 fetches.
- R6: Each burst length equals the smallest of three values: the device bytes left, the region bytes left, and 64. Its address is the region address plus all bytes already requested from that region.
- R7: `bst_write` equals the `dir_wr` value captured at start for every burst of the walk (1 = device to memory, 0 = memory to device).
- R8: A burst request holds `bst_valid`, `bst_addr`, `bst_len` and `bst_write` unchanged until `bst_ready` is seen. Only then is the next request formed.
- R9: `done` pulses for one cycle once the device byte count reaches zero. This test comes before any table-end test, so a count of zero ends the walk with `done` and no fetch. An exact fit at a last descriptor also gives `done`.
- R10: A `clr` pulse while a burst request is waiting withdraws it. It zeroes the region address, remaining length and last flag, so the walk continues with the next descriptor and the device count is unchanged.
- R11: After reset and between walks, `busy`, `dsc_req`, `bst_valid`, `done` and `tbl_end` are low. At most one of `dsc_req` and `bst_valid` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (acted on when idle) |
| dir_wr | input | 1 | 1: device to memory, 0: memory to device |
| tbl_base | input | AW | Byte address of the first descriptor |
| dev_bytes | input | DEV_W | Bytes the device side has to move |
| clr | input | 1 | Drop the rest of the current region |
| dsc_req | output | 1 | Descriptor read request |
| dsc_addr | output | AW | Descriptor address |
| dsc_ack | input | 1 | Descriptor data valid, request complete |
| dsc_rdata | input | 64 | Descriptor contents |
| bst_valid | output | 1 | Burst request pending |
| bst_ready | input | 1 | Interconnect accepts the burst |
| bst_write | output | 1 | Burst writes memory |
| bst_addr | output | AW | Burst start byte address |
| bst_len | output | BL_W | Burst length in bytes |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse: device bytes exhausted |
| tbl_end | output | 1 | One-cycle pulse: table ended first |

## Verification
The bench walks tables built arithmetically: three regions with an exact fit, with the device running short, and with the device running long. The first two end in `done` and the third in `tbl_end`. Each burst is predicted by an independent model. A sweep over device byte counts, in both directions, shows where the burst splits fall at region edges and at the 64-byte cap. Control words with junk in the ignored bits must produce the same requests as clean ones. A zero-count descriptor must produce a full 64 KiB of bursts. A table with no last flag must stop after 512 fetches. A mid-walk clear must move the next burst to the following region's address. Ready and acknowledge are withheld on a fixed cadence, so that held requests are checked on every waiting cycle.

// File: rtl/sg_walk_pkg.sv
package sg_walk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_FETCH = 2'd2,
    ST_BURST = 2'd3
  } walk_st_t;

  localparam int DESC_BYTES  = 8;
  localparam int REG_LEN_W   = 17;
  localparam int LAST_BIT    = 31;
  localparam logic [REG_LEN_W-1:0] FULL_REGION = 17'h10000;

endpackage

// File: rtl/sg_desc_decode.sv
module sg_desc_decode
  import sg_walk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [63:0]          desc,
  output logic [AW-1:0]        reg_addr,
  output logic [REG_LEN_W-1:0] reg_len,
  output logic                 reg_last
);

  logic [31:0] ctrl;
  logic [15:0] cnt;
  logic        unused_ctrl_bits;

  assign ctrl             = desc[63:32];
  assign cnt              = {ctrl[15:1], 1'b0};
  assign unused_ctrl_bits = ^{ctrl[30:16], ctrl[0]};
  assign reg_addr         = AW'(desc[31:0]);
  assign reg_last         = ctrl[LAST_BIT];

  always_comb begin
    if (cnt == 16'd0) reg_len = FULL_REGION;
    else              reg_len = {1'b0, cnt};
  end

  // R2: decoded region length is never zero
  always_comb begin
    a_r2_len_nonzero: assert (reg_len != '0);
    // R1: region length is always even
    a_r1_len_even: assert (reg_len[0] == 1'b0);
  end

endmodule

// File: rtl/sg_burst_sizer.sv
module sg_burst_sizer
  import sg_walk_pkg::*;
#(
  parameter int DEV_W       = 20,
  parameter int BURST_BYTES = 64,
  parameter int BL_W        = 7
) (
  input  logic [DEV_W-1:0]     dev_rem,
  input  logic [REG_LEN_W-1:0] reg_rem,
  output logic [BL_W-1:0]      len
);

  localparam int CW = (DEV_W > REG_LEN_W) ? DEV_W : REG_LEN_W;

  logic [CW-1:0] dev_w, reg_w, small_w;

  assign dev_w   = CW'(dev_rem);
  assign reg_w   = CW'(reg_rem);
  assign small_w = (dev_w < reg_w) ? dev_w : reg_w;

  always_comb begin
    if (small_w > CW'(BURST_BYTES)) len = BL_W'(BURST_BYTES);
    else                            len = BL_W'(small_w);
  end

endmodule

// File: rtl/sg_table_guard.sv
module sg_table_guard #(
  parameter int AW         = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] base,
  input  logic          last,
  output logic          exhausted
);

  logic [AW-1:0] consumed;

  assign consumed  = ptr - base;
  assign exhausted = last || (consumed >= AW'(PAGE_BYTES));

endmodule

// File: rtl/sg_walker.sv
module sg_walker
  import sg_walk_pkg::*;
#(
  parameter int AW              = 32,
  parameter int DEV_W           = 20,
  parameter int WORD_BYTES      = 4,
  parameter int MAX_BURST_WORDS = 16,
  parameter int PAGE_BYTES      = 4096,
  localparam int BURST_BYTES    = WORD_BYTES * MAX_BURST_WORDS,
  localparam int BL_W           = $clog2(BURST_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             dir_wr,
  input  logic [AW-1:0]    tbl_base,
  input  logic [DEV_W-1:0] dev_bytes,
  input  logic             clr,
  output logic             dsc_req,
  output logic [AW-1:0]    dsc_addr,
  input  logic             dsc_ack,
  input  logic [63:0]      dsc_rdata,
  output logic             bst_valid,
  input  logic             bst_ready,
  output logic             bst_write,
  output logic [AW-1:0]    bst_addr,
  output logic [BL_W-1:0]  bst_len,
  output logic             busy,
  output logic             done,
  output logic             tbl_end
);

  walk_st_t             state;
  logic [AW-1:0]        ptr_q, base_q, reg_addr_q;
  logic [DEV_W-1:0]     dev_rem_q;
  logic [REG_LEN_W-1:0] reg_rem_q;
  logic                 reg_last_q, dir_q;

  logic [AW-1:0]        dec_addr;
  logic [REG_LEN_W-1:0] dec_len;
  logic                 dec_last;
  logic [BL_W-1:0]      next_len;
  logic                 tbl_done;
  logic                 take_desc;

  sg_desc_decode #(.AW(AW)) u_decode (
    .desc     (dsc_rdata),
    .reg_addr (dec_addr),
    .reg_len  (dec_len),
    .reg_last (dec_last)
  );

  sg_burst_sizer #(.DEV_W(DEV_W), .BURST_BYTES(BURST_BYTES), .BL_W(BL_W)) u_sizer (
    .dev_rem (dev_rem_q),
    .reg_rem (reg_rem_q),
    .len     (next_len)
  );

  sg_table_guard #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_guard (
    .ptr       (ptr_q),
    .base      (base_q),
    .last      (reg_last_q),
    .exhausted (tbl_done)
  );

  assign take_desc = (state == ST_FETCH) && dsc_ack;
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ptr_q      <= '0;
      base_q     <= '0;
      reg_addr_q <= '0;
      dev_rem_q  <= '0;
      reg_rem_q  <= '0;
      reg_last_q <= 1'b0;
      dir_q      <= 1'b0;
      dsc_req    <= 1'b0;
      dsc_addr   <= '0;
      bst_valid  <= 1'b0;
      bst_write  <= 1'b0;
      bst_addr   <= '0;
      bst_len    <= '0;
      done       <= 1'b0;
      tbl_end    <= 1'b0;
    end else begin
      done    <= 1'b0;
      tbl_end <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            base_q     <= tbl_base;
            ptr_q      <= tbl_base;
            dev_rem_q  <= dev_bytes;
            reg_addr_q <= '0;
            reg_rem_q  <= '0;
            reg_last_q <= 1'b0;
            dir_q      <= dir_wr;
            state      <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (dev_rem_q == '0) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (reg_rem_q == '0) begin
            if (tbl_done) begin
              tbl_end <= 1'b1;
              state   <= ST_IDLE;
            end else begin
              dsc_req  <= 1'b1;
              dsc_addr <= ptr_q;
              state    <= ST_FETCH;
            end
          end else begin
            bst_valid <= 1'b1;
            bst_addr  <= reg_addr_q;
            bst_len   <= next_len;
            bst_write <= dir_q;
            state     <= ST_BURST;
          end
        end
        ST_FETCH: begin
          if (dsc_ack) begin
            dsc_req    <= 1'b0;
            reg_addr_q <= dec_addr;
            reg_rem_q  <= dec_len;
            reg_last_q <= dec_last;
            ptr_q      <= ptr_q + AW'(DESC_BYTES);
            state      <= ST_CHECK;
          end
        end
        ST_BURST: begin
          if (bst_ready) begin
            bst_valid  <= 1'b0;
            dev_rem_q  <= dev_rem_q - DEV_W'(bst_len);
            reg_addr_q <= reg_addr_q + AW'(bst_len);
            reg_rem_q  <= reg_rem_q - REG_LEN_W'(bst_len);
            state      <= ST_CHECK;
          end else if (clr) begin
            bst_valid <= 1'b0;
            state     <= ST_CHECK;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (clr && !take_desc) begin
        reg_addr_q <= '0;
        reg_rem_q  <= '0;
        reg_last_q <= 1'b0;
      end
    end
  end

  // R8: a waiting burst keeps its fields until accepted or withdrawn
  a_r8_burst_hold: assert property (@(posedge clk) disable iff (rst)
    (bst_valid && !bst_ready && !clr) |=>
      (bst_valid && $stable(bst_addr) && $stable(bst_len) && $stable(bst_write)));

  // R4: a descriptor request holds until acknowledged
  a_r4_fetch_hold: assert property (@(posedge clk) disable iff (rst)
    (dsc_req && !dsc_ack) |=> (dsc_req && $stable(dsc_addr)));

  // R4: a fetch starts only with the region used up
  a_r4_fetch_empty: assert property (@(posedge clk) disable iff (rst)
    $rose(dsc_req) |-> (reg_rem_q == '0));

  // R6: burst length within the cap and the device bytes left
  a_r6_len_cap: assert property (@(posedge clk) disable iff (rst)
    bst_valid |-> ((bst_len != '0) && (bst_len <= BL_W'(BURST_BYTES))
                   && (DEV_W'(bst_len) <= dev_rem_q)));

  // R9: the two end pulses exclude each other and leave the block idle
  a_r9_end_exclusive: assert property (@(posedge clk) disable iff (rst)
    (done || tbl_end) |-> (!(done && tbl_end) && !busy));

  // R11: never two requests at once
  a_r11_one_request: assert property (@(posedge clk) disable iff (rst)
    !(dsc_req && bst_valid));

endmodule

// File: tb/sg_walker_bench.sv
module sg_walker_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 32;
  localparam int DEV_W = 20;
  localparam int BL_W  = 7;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic             dir_wr = 1'b0;
  logic [AW-1:0]    tbl_base = '0;
  logic [DEV_W-1:0] dev_bytes = '0;
  logic             clr = 1'b0;
  logic             dsc_req;
  logic [AW-1:0]    dsc_addr;
  logic             dsc_ack = 1'b0;
  logic [63:0]      dsc_rdata = '0;
  logic             bst_valid;
  logic             bst_ready = 1'b0;
  logic             bst_write;
  logic [AW-1:0]    bst_addr;
  logic [BL_W-1:0]  bst_len;
  logic             busy, done, tbl_end;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  sg_walker u_sg_walker (
    .clk(clk), .rst(rst), .start(start), .dir_wr(dir_wr), .tbl_base(tbl_base),
    .dev_bytes(dev_bytes), .clr(clr), .dsc_req(dsc_req), .dsc_addr(dsc_addr),
    .dsc_ack(dsc_ack), .dsc_rdata(dsc_rdata), .bst_valid(bst_valid),
    .bst_ready(bst_ready), .bst_write(bst_write), .bst_addr(bst_addr),
    .bst_len(bst_len), .busy(busy), .done(done), .tbl_end(tbl_end)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog R11 actual=%0d expected=%0d", cyc, 190000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic longint len_tab(input int idx);
    case (idx)
      0: return 100;
      1: return 40;
      2: return 200;
      default: return 0;
    endcase
  endfunction

  function automatic logic [63:0] desc_of(input int mode, input int idx);
    logic [31:0] a, c;
    case (mode)
      0: begin
        a = 32'h1000_0006 + 32'(idx) * 32'h1_0000;
        c = 32'(len_tab(idx));
        if (idx >= 2) c = c | 32'h8000_0000;
      end
      1: begin
        a = 32'h1000_0006 + 32'(idx) * 32'h1_0000;
        c = 32'(len_tab(idx)) | 32'h3A5C_0001;
        if (idx >= 2) c = c | 32'h8000_0000;
      end
      2: begin
        a = 32'h4000_0000 + 32'(idx) * 32'h10_0000;
        c = (idx == 0) ? 32'h0 : 32'h8000_1000;
      end
      default: begin
        a = 32'(idx) * 32'h100;
        c = 32'h0000_0002;
      end
    endcase
    return {c, a};
  endfunction

  task automatic run_walk(input int mode, input bit d, input int dev,
                          input longint base, input int clr_at, input int exp_end,
                          input int exp_fetch, input int exp_burst, input string tag);
    longint m_dev, m_rem, m_addr, m_ptr, el, ctl, cl;
    bit m_last, fin, clr_done;
    int idx, nfetch, nburst;
    logic [63:0] dd;
    m_dev = dev; m_rem = 0; m_addr = 0; m_ptr = base; m_last = 0;
    fin = 0; clr_done = 0; idx = 0; nfetch = 0; nburst = 0;
    @(negedge clk);
    start = 1'b1; dir_wr = d; tbl_base = AW'(base); dev_bytes = DEV_W'(dev);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11", "busy after start", busy, 1);
    for (int t = 0; t < 20000 && !fin; t++) begin
      @(negedge clk);
      dsc_ack = 1'b0; bst_ready = 1'b0; clr = 1'b0;
      if (dsc_req) begin
        chk(m_dev > 0 && m_rem == 0 && !m_last && (m_ptr - base) < 4096,
            "R4", "fetch permitted", 1, 0);
        chk(dsc_addr == AW'(m_ptr), "R4", "descriptor address", dsc_addr, m_ptr);
        if ((t % 3) != 0) begin
          dd = desc_of(mode, idx);
          dsc_ack = 1'b1;
          dsc_rdata = dd;
          ctl = longint'(dd[63:32]);
          cl = ctl % 65536;
          cl = cl - (cl % 2);
          if (cl == 0) cl = 65536;
          m_rem = cl;
          m_addr = longint'(dd[31:0]);
          m_last = (ctl >= 64'h8000_0000);
          m_ptr = m_ptr + 8;
          idx++; nfetch++;
        end
      end
      if (bst_valid) begin
        el = m_dev;
        if (m_rem < el) el = m_rem;
        if (el > 64) el = 64;
        chk(longint'(bst_len) == el, "R6", "burst length", bst_len, el);
        chk(longint'(bst_addr) == m_addr, "R6", "burst address", bst_addr, m_addr);
        chk(bst_write == d, "R7", "burst direction", bst_write, d);
        if (clr_at == nburst && !clr_done) begin
          clr = 1'b1; clr_done = 1;
          m_rem = 0; m_last = 0; m_addr = 0;
        end else if ((t % 4) != 1) begin
          bst_ready = 1'b1;
          m_dev = m_dev - el; m_addr = m_addr + el; m_rem = m_rem - el;
          nburst++;
        end
      end
      if (done || tbl_end) begin
        fin = 1;
        chk(!busy, "R11", "idle at end", busy, 0);
        if (done) begin
          chk(exp_end == 0, tag, "ended with done", 0, exp_end);
          chk(m_dev == 0, "R9", "device bytes left at done", m_dev, 0);
        end else begin
          chk(exp_end == 1, tag, "ended with table end", 1, exp_end);
          chk(m_dev > 0 && m_rem == 0 && (m_last || (m_ptr - base) >= 4096),
              "R3", "table end condition", m_ptr - base, 4096);
        end
      end
    end
    dsc_ack = 1'b0; bst_ready = 1'b0; clr = 1'b0;
    chk(fin, tag, "walk finished", fin, 1);
    if (exp_fetch >= 0) chk(nfetch == exp_fetch, tag, "fetch count", nfetch, exp_fetch);
    if (exp_burst >= 0) chk(nburst == exp_burst, tag, "burst count", nburst, exp_burst);
    @(negedge clk);
    chk(!busy && !dsc_req && !bst_valid && !done && !tbl_end, "R11", "idle between walks",
        {busy, dsc_req, bst_valid, done, tbl_end}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !dsc_req && !bst_valid && !done && !tbl_end, "R11", "reset state",
        {busy, dsc_req, bst_valid, done, tbl_end}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !dsc_req && !bst_valid, "R11", "idle after reset",
        {busy, dsc_req, bst_valid}, 0);

    // R9: exact fit at the last descriptor gives done
    run_walk(0, 1'b1, 340, 64'h2000, -1, 0, 3, 7, "R9");
    // R6: device runs short inside the third region
    run_walk(0, 1'b0, 200, 64'h2008, -1, 0, 3, -1, "R6");
    // R3: device runs long, last flag ends the table
    run_walk(0, 1'b1, 1000, 64'h3000, -1, 1, 3, -1, "R3");
    // R1: junk in ignored control bits changes nothing
    run_walk(1, 1'b0, 340, 64'h2000, -1, 0, 3, 7, "R1");
    // R2: zero count means 64 KiB (1024 + 64 bursts)
    run_walk(2, 1'b1, 69632, 64'h5000, -1, 0, 2, 1088, "R2");
    // R5: no last flag, one-page guard after 512 fetches
    run_walk(3, 1'b0, 5000, 64'h2000, -1, 1, 512, 512, "R5");
    // R9: zero device bytes ends at once without a fetch
    run_walk(0, 1'b1, 0, 64'h2000, -1, 0, 0, 0, "R9");
    // R10: clear on the second burst skips the rest of region one
    run_walk(0, 1'b1, 340, 64'h2000, 1, 1, 3, 6, "R10");
    // R6 sweep over device byte counts, both directions
    for (int dv = 0; dv <= 340; dv += 20) begin
      for (int dr = 0; dr < 2; dr++) begin
        int ef;
        ef = (dv == 0) ? 0 : (dv <= 100) ? 1 : (dv <= 140) ? 2 : 3;
        run_walk(0, dr[0], dv, 64'h6000, -1, 0, ef, -1, "R6");
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule